// File: doc/BRIEF.md
# PC-Triggered Configuration Launch Sequencer

This block sits beside a processor pipeline and a coarse-grained execution array. It keeps a small cache of array configurations. Each one is keyed by the program counter of the first instruction of the code sequence it replaces. A configuration generator fills the cache through a write port while the processor keeps running. Each cache line holds a configuration word, the PC at which execution continues afterwards, a list of source register indices and a list of destination register indices.

The block compares every valid fetch PC against the stored keys. On a match it halts the processor and runs a fixed sequence:
1. Hand the configuration word to the array.
2. Read each source operand from the register file into a context register that drives the array's operand buses.
3. Start the array and wait for its done handshake.
4. Write each result back to the register file.
5. Pulse a resume strobe together with the continuation PC, which moves the processor past the accelerated sequence.

Top module: `cfg_launch_seq`

## Requirements
- R1: A write (`wr_en_i`) is accepted in any phase and never asserts `halt_o` by itself.
- R2: After reset every entry is invalid. A cycle with `fetch_valid_i` high, in which `fetch_pc_i` equals the key of a valid entry and the block is idle, raises `halt_o` in the following cycle. A PC that matches no valid key leaves `halt_o` low.
- R3: A write whose key equals a valid stored key overwrites that entry in place. Its new contents are used by the next launch, and it does not advance the replacement pointer.
- R4: A write with a new key fills the entry at a round-robin pointer that starts at entry 0 and advances by one on each such write. With 4 entries, the fifth distinct key evicts the first one written.
- R5: The first halted cycle is the load phase: `arr_cfg_load_o` is high for exactly that cycle, with the stored word on `arr_cfg_o`. It is followed by NOPS fetch cycles. Fetch cycle i puts source index i on `rf_rd_idx_o`; index i is `wr_src_idx_i[i*RF_IDX_W +: RF_IDX_W]`. The captured operand i then appears on `ctx_o[i*DATA_W +: DATA_W]`.
- R6: After the last fetch cycle, `arr_go_o` stays high until a cycle in which `arr_done_i` is sampled high. In that cycle `arr_res_i` is captured.
- R7: Then come NRES writeback cycles. Cycle j drives `rf_wr_en_o` high, with destination index j (`wr_dst_idx_i[j*RF_IDX_W +: RF_IDX_W]`) on `rf_wr_idx_o` and result j (`arr_res_i[j*DATA_W +: DATA_W]`) on `rf_wr_data_o`.
- R8: After writeback, `resume_o` is high for one cycle with the stored continuation PC on `next_pc_o`. `halt_o` is low in the cycle after that.
- R9: The launched entry is copied when the launch begins. A write to that same key during the launch does not change the running sequence.
- R10: Fetches presented while `halt_o` is high are ignored and do not restart or lengthen the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Fetch PC is valid this cycle |
| fetch_pc_i | input | PC_W | Processor fetch PC |
| wr_en_i | input | 1 | Store a configuration |
| wr_tag_pc_i | input | PC_W | Key: PC of first replaced instruction |
| wr_exit_pc_i | input | PC_W | Continuation PC after the sequence |
| wr_cfg_i | input | CFG_W | Array configuration word |
| wr_src_idx_i | input | NOPS*RF_IDX_W | Source register indices, index i at slice i |
| wr_dst_idx_i | input | NRES*RF_IDX_W | Destination register indices, index j at slice j |
| halt_o | output | 1 | Processor held |
| resume_o | output | 1 | One-cycle release strobe |
| next_pc_o | output | PC_W | Continuation PC, valid with resume_o |
| arr_cfg_load_o | output | 1 | Configuration load strobe |
| arr_cfg_o | output | CFG_W | Configuration word to the array |
| arr_go_o | output | 1 | Array run request |
| arr_done_i | input | 1 | Array run acknowledge |
| arr_res_i | input | NRES*DATA_W | Array results |
| ctx_o | output | NOPS*DATA_W | Context registers driving the operand buses |
| rf_rd_idx_o | output | RF_IDX_W | Register file read index |
| rf_rd_data_i | input | DATA_W | Register file read data, same cycle |
| rf_wr_en_o | output | 1 | Register file write enable |
| rf_wr_idx_o | output | RF_IDX_W | Register file write index |
| rf_wr_data_o | output | DATA_W | Register file write data |

## Verification
The timing of a hit is fixed. `halt_o`, `arr_cfg_load_o` and the configuration word are due one cycle after the matching fetch. Source index i is due on `rf_rd_idx_o` 2+i cycles after the fetch. `arr_go_o` and the full `ctx_o` are due after 2+NOPS cycles. Writeback slot j is due j+1 cycles after the cycle in which done is sampled, and `resume_o` follows one cycle after the last writeback slot. The bench drives every input at the falling edge and samples outputs at the next falling edge, so each check falls exactly on the cycle its requirement names. It sweeps 64 consecutive PCs, so every hit and every miss is observed one cycle after its fetch.

// File: rtl/cls_pkg.sv
package cls_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_FETCH,
    PH_EXEC,
    PH_WB,
    PH_RESUME
  } phase_t;
endpackage

// File: rtl/cls_tag_store.sv
module cls_tag_store #(
  parameter int ENTRIES = 4,
  parameter int PC_W    = 16,
  parameter int PAY_W   = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [PC_W-1:0]  wr_tag_i,
  input  logic [PAY_W-1:0] wr_pay_i,
  input  logic [PC_W-1:0]  lk_pc_i,
  output logic             lk_hit_o,
  output logic [PAY_W-1:0] lk_pay_o
);
  localparam int EIDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  logic [PAY_W-1:0]   pay_q [ENTRIES];
  logic [EIDX_W-1:0]  rr_q, rr_d;
  logic [ENTRIES-1:0] wr_match, lk_match;
  logic               wr_hit;
  logic [EIDX_W-1:0]  wr_slot;

  genvar e;
  generate
    for (e = 0; e < ENTRIES; e++) begin : g_ent
      assign wr_match[e] = valid_q[e] && (tag_q[e] == wr_tag_i);
      assign lk_match[e] = valid_q[e] && (tag_q[e] == lk_pc_i);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q[e] <= 1'b0;
        else if (wr_en_i && (wr_slot == EIDX_W'(e))) valid_q[e] <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (wr_en_i && (wr_slot == EIDX_W'(e))) begin
          tag_q[e] <= wr_tag_i;
          pay_q[e] <= wr_pay_i;
        end
      end
    end
  endgenerate

  always_comb begin
    wr_hit  = 1'b0;
    wr_slot = rr_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_match[i]) begin
        wr_hit  = 1'b1;
        wr_slot = EIDX_W'(i);
      end
    end
  end

  always_comb begin
    lk_pay_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_pay_o = lk_pay_o | pay_q[i];
    end
  end
  assign lk_hit_o = |lk_match;

  always_comb begin
    rr_d = rr_q;
    if (wr_en_i && !wr_hit) begin
      rr_d = (rr_q == EIDX_W'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // R3: replace-on-hit keeps every key unique, so at most one entry matches
  a_r3_unique_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  a_r3_unique_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_match));
endmodule

// File: rtl/cls_ctx_regs.sv
module cls_ctx_regs #(
  parameter int NOPS   = 2,
  parameter int NRES   = 2,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 1
) (
  input  logic                   clk,
  input  logic                   cap_op_en_i,
  input  logic [CNT_W-1:0]       cap_op_idx_i,
  input  logic [DATA_W-1:0]      rd_data_i,
  input  logic                   cap_res_en_i,
  input  logic [NRES*DATA_W-1:0] res_i,
  input  logic [CNT_W-1:0]       wb_idx_i,
  output logic [DATA_W-1:0]      wb_data_o,
  output logic [NOPS*DATA_W-1:0] ctx_o
);
  logic [DATA_W-1:0] res_q [NRES];

  genvar i, j;
  generate
    for (i = 0; i < NOPS; i++) begin : g_op
      logic [DATA_W-1:0] op_q;
      always_ff @(posedge clk) begin
        if (cap_op_en_i && (cap_op_idx_i == CNT_W'(i))) op_q <= rd_data_i;
      end
      assign ctx_o[i*DATA_W +: DATA_W] = op_q;
    end
    for (j = 0; j < NRES; j++) begin : g_res
      always_ff @(posedge clk) begin
        if (cap_res_en_i) res_q[j] <= res_i[j*DATA_W +: DATA_W];
      end
    end
  endgenerate

  always_comb begin
    wb_data_o = '0;
    for (int k = 0; k < NRES; k++) begin
      if (wb_idx_i == CNT_W'(k)) wb_data_o = res_q[k];
    end
  end
endmodule

// File: rtl/cls_phase_fsm.sv
module cls_phase_fsm
  import cls_pkg::*;
#(
  parameter int NOPS  = 2,
  parameter int NRES  = 2,
  parameter int CNT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             arr_done_i,
  output phase_t           phase_o,
  output logic [CNT_W-1:0] cnt_o
);
  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE:   if (start_i) phase_d = PH_LOAD;
      PH_LOAD: begin
        phase_d = PH_FETCH;
        cnt_d   = '0;
      end
      PH_FETCH: begin
        if (cnt_q == CNT_W'(NOPS-1)) begin
          phase_d = PH_EXEC;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_EXEC: begin
        if (arr_done_i) begin
          phase_d = PH_WB;
          cnt_d   = '0;
        end
      end
      PH_WB: begin
        if (cnt_q == CNT_W'(NRES-1)) phase_d = PH_RESUME;
        else                         cnt_d   = cnt_q + 1'b1;
      end
      PH_RESUME: phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  // R5: the load phase lasts one cycle and hands over to fetch slot 0
  a_r5_load_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOAD) |=> (phase_q == PH_FETCH && cnt_q == '0));
  // R6: execution is held until the array acknowledges
  a_r6_exec_waits_done: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC && !arr_done_i) |=> (phase_q == PH_EXEC));
  // R8: the resume phase is a single cycle
  a_r8_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RESUME) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/cfg_launch_seq.sv
module cfg_launch_seq
  import cls_pkg::*;
#(
  parameter int ENTRIES  = 4,
  parameter int PC_W     = 16,
  parameter int CFG_W    = 12,
  parameter int DATA_W   = 16,
  parameter int NOPS     = 2,
  parameter int NRES     = 2,
  parameter int RF_IDX_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fetch_valid_i,
  input  logic [PC_W-1:0]          fetch_pc_i,
  input  logic                     wr_en_i,
  input  logic [PC_W-1:0]          wr_tag_pc_i,
  input  logic [PC_W-1:0]          wr_exit_pc_i,
  input  logic [CFG_W-1:0]         wr_cfg_i,
  input  logic [NOPS*RF_IDX_W-1:0] wr_src_idx_i,
  input  logic [NRES*RF_IDX_W-1:0] wr_dst_idx_i,
  output logic                     halt_o,
  output logic                     resume_o,
  output logic [PC_W-1:0]          next_pc_o,
  output logic                     arr_cfg_load_o,
  output logic [CFG_W-1:0]         arr_cfg_o,
  output logic                     arr_go_o,
  input  logic                     arr_done_i,
  input  logic [NRES*DATA_W-1:0]   arr_res_i,
  output logic [NOPS*DATA_W-1:0]   ctx_o,
  output logic [RF_IDX_W-1:0]      rf_rd_idx_o,
  input  logic [DATA_W-1:0]        rf_rd_data_i,
  output logic                     rf_wr_en_o,
  output logic [RF_IDX_W-1:0]      rf_wr_idx_o,
  output logic [DATA_W-1:0]        rf_wr_data_o
);
  localparam int MAXC     = (NOPS > NRES) ? NOPS : NRES;
  localparam int CNT_W    = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam int DST_LSB  = 0;
  localparam int SRC_LSB  = DST_LSB + NRES*RF_IDX_W;
  localparam int CFG_LSB  = SRC_LSB + NOPS*RF_IDX_W;
  localparam int EXIT_LSB = CFG_LSB + CFG_W;
  localparam int PAY_W    = EXIT_LSB + PC_W;

  logic             lk_hit, launch;
  logic [PAY_W-1:0] lk_pay, act_q;
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [NOPS*RF_IDX_W-1:0] act_src;
  logic [NRES*RF_IDX_W-1:0] act_dst;

  cls_tag_store #(.ENTRIES(ENTRIES), .PC_W(PC_W), .PAY_W(PAY_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_tag_i (wr_tag_pc_i),
    .wr_pay_i ({wr_exit_pc_i, wr_cfg_i, wr_src_idx_i, wr_dst_idx_i}),
    .lk_pc_i  (fetch_pc_i),
    .lk_hit_o (lk_hit),
    .lk_pay_o (lk_pay)
  );

  assign launch = fetch_valid_i && lk_hit && (phase == PH_IDLE);

  // copy of the launched entry, enabled only at launch
  always_ff @(posedge clk) begin
    if (launch) act_q <= lk_pay;
  end

  cls_phase_fsm #(.NOPS(NOPS), .NRES(NRES), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (launch),
    .arr_done_i (arr_done_i),
    .phase_o    (phase),
    .cnt_o      (cnt)
  );

  cls_ctx_regs #(.NOPS(NOPS), .NRES(NRES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctx (
    .clk          (clk),
    .cap_op_en_i  (phase == PH_FETCH),
    .cap_op_idx_i (cnt),
    .rd_data_i    (rf_rd_data_i),
    .cap_res_en_i ((phase == PH_EXEC) && arr_done_i),
    .res_i        (arr_res_i),
    .wb_idx_i     (cnt),
    .wb_data_o    (rf_wr_data_o),
    .ctx_o        (ctx_o)
  );

  assign act_src        = act_q[SRC_LSB +: NOPS*RF_IDX_W];
  assign act_dst        = act_q[DST_LSB +: NRES*RF_IDX_W];
  assign halt_o         = (phase != PH_IDLE);
  assign arr_cfg_load_o = (phase == PH_LOAD);
  assign arr_cfg_o      = act_q[CFG_LSB +: CFG_W];
  assign rf_rd_idx_o    = act_src[cnt*RF_IDX_W +: RF_IDX_W];
  assign arr_go_o       = (phase == PH_EXEC);
  assign rf_wr_en_o     = (phase == PH_WB);
  assign rf_wr_idx_o    = act_dst[cnt*RF_IDX_W +: RF_IDX_W];
  assign resume_o       = (phase == PH_RESUME);
  assign next_pc_o      = act_q[EXIT_LSB +: PC_W];

  // R2: an idle-time fetch hit halts the processor one cycle later
  a_r2_halt_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_i && lk_hit && !halt_o) |=> halt_o);
  // R8: the processor is released right after the resume strobe
  a_r8_release_after_resume: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> (!halt_o && !resume_o));
  // R9: the configuration seen by the array stays fixed for a whole launch
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && $past(halt_o)) |-> $stable(arr_cfg_o));
  // R6: the run request holds until the acknowledge is seen
  a_r6_go_held: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_go_o && !arr_done_i) |=> arr_go_o);
endmodule

// File: tb/tb_cfg_launch_seq.sv
module tb_cfg_launch_seq;
  logic clk, rst_n;
  logic fetch_valid;
  logic [15:0] fetch_pc;
  logic wr_en;
  logic [15:0] wr_tag, wr_exit;
  logic [11:0] wr_cfg;
  logic [5:0] wr_src, wr_dst;
  logic halt, resume, cfg_load, arr_go, arr_done, rf_wr_en;
  logic [15:0] next_pc;
  logic [11:0] arr_cfg;
  logic [31:0] arr_res, ctx;
  logic [2:0] rf_rd_idx, rf_wr_idx;
  logic [15:0] rf_rd_data, rf_wr_data;
  logic [15:0] rf [8];

  int n_cmp = 0;
  int n_bad = 0;

  cfg_launch_seq dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid_i(fetch_valid), .fetch_pc_i(fetch_pc),
    .wr_en_i(wr_en), .wr_tag_pc_i(wr_tag), .wr_exit_pc_i(wr_exit),
    .wr_cfg_i(wr_cfg), .wr_src_idx_i(wr_src), .wr_dst_idx_i(wr_dst),
    .halt_o(halt), .resume_o(resume), .next_pc_o(next_pc),
    .arr_cfg_load_o(cfg_load), .arr_cfg_o(arr_cfg), .arr_go_o(arr_go),
    .arr_done_i(arr_done), .arr_res_i(arr_res), .ctx_o(ctx),
    .rf_rd_idx_o(rf_rd_idx), .rf_rd_data_i(rf_rd_data),
    .rf_wr_en_o(rf_wr_en), .rf_wr_idx_o(rf_wr_idx), .rf_wr_data_o(rf_wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // register file model: combinational read, clocked write
  assign rf_rd_data = rf[rf_rd_idx];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= 16'(i * 16'h0111 + 5);
    end else if (rf_wr_en) begin
      rf[rf_wr_idx] <= rf_wr_data;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] f_cfg(input logic [15:0] pc);
    return 12'(pc ^ 16'h05A5);
  endfunction
  function automatic logic [15:0] f_exit(input logic [15:0] pc);
    return pc + 16'h0020;
  endfunction

  task automatic write_cfg(input logic [15:0] tag, input logic [15:0] ex,
                           input logic [11:0] cf, input logic [2:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_tag = tag; wr_exit = ex; wr_cfg = cf;
    wr_src = {3'(b + 1), b};
    wr_dst = {3'(b + 5), 3'(b + 3)};
    @(negedge clk);
    wr_en = 1'b0;
    check("R1 write does not halt", {31'd0, halt}, 32'd0);
  endtask

  task automatic miss(input logic [15:0] pc, input string req);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc;
    @(negedge clk);
    fetch_valid = 1'b0;
    check(req, {31'd0, halt}, 32'd0);
  endtask

  task automatic launch(input logic [15:0] pc, input logic [15:0] ex,
                        input logic [11:0] cf, input logic [2:0] b,
                        input int lat, input bit noisy, input bit midwr);
    logic [2:0] s0, s1, d0, d1;
    logic [15:0] op0, op1, r0, r1;
    s0 = b; s1 = 3'(b + 1); d0 = 3'(b + 3); d1 = 3'(b + 5);
    op0 = rf[s0]; op1 = rf[s1];
    r0 = op0 + op1 + {4'd0, cf};
    r1 = op0 ^ op1 ^ 16'h3C3C;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc;
    @(negedge clk);                       // load phase
    fetch_valid = noisy;
    check("R2 halt after hit", {31'd0, halt}, 32'd1);
    check("R5 load strobe", {31'd0, cfg_load}, 32'd1);
    check("R5 cfg word", {20'd0, arr_cfg}, {20'd0, cf});
    @(negedge clk);                       // fetch slot 0
    check("R5 src0 index", {29'd0, rf_rd_idx}, {29'd0, s0});
    check("R5 load one cycle", {31'd0, cfg_load}, 32'd0);
    @(negedge clk);                       // fetch slot 1
    check("R5 src1 index", {29'd0, rf_rd_idx}, {29'd0, s1});
    @(negedge clk);                       // exec
    check("R6 go raised", {31'd0, arr_go}, 32'd1);
    check("R5 context regs", ctx, {op1, op0});
    if (midwr) begin
      wr_en = 1'b1; wr_tag = pc; wr_exit = ex ^ 16'h0F0F;
      wr_cfg = cf ^ 12'hFFF; wr_src = {3'(b + 1), b};
      wr_dst = {3'(b + 5), 3'(b + 3)};
    end
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      check("R6 go held", {31'd0, arr_go}, 32'd1);
    end
    arr_done = 1'b1; arr_res = {r1, r0};
    @(negedge clk);                       // writeback slot 0
    arr_done = 1'b0; arr_res = '0;
    check("R7 wb0 enable", {31'd0, rf_wr_en}, 32'd1);
    check("R7 wb0 index", {29'd0, rf_wr_idx}, {29'd0, d0});
    check("R7 wb0 data", {16'd0, rf_wr_data}, {16'd0, r0});
    check("R6 go dropped", {31'd0, arr_go}, 32'd0);
    @(negedge clk);                       // writeback slot 1
    check("R7 wb1 index", {29'd0, rf_wr_idx}, {29'd0, d1});
    check("R7 wb1 data", {16'd0, rf_wr_data}, {16'd0, r1});
    @(negedge clk);                       // resume
    fetch_valid = 1'b0;
    check("R8 resume strobe", {31'd0, resume}, 32'd1);
    check(midwr ? "R9 exit pc kept" : "R8 next pc", {16'd0, next_pc}, {16'd0, ex});
    check("R10 still halted at resume", {31'd0, halt}, 32'd1);
    @(negedge clk);
    check("R8 released", {31'd0, halt}, 32'd0);
    check("R8 resume single", {31'd0, resume}, 32'd0);
    check("R7 rf dst0", {16'd0, rf[d0]}, {16'd0, r0});
    check("R7 rf dst1", {16'd0, rf[d1]}, {16'd0, r1});
  endtask

  function automatic bit is_tag(input logic [15:0] pc);
    return (pc == 16'h0104) || (pc == 16'h0110) || (pc == 16'h0120) || (pc == 16'h0134);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_pc = '0; wr_en = 1'b0;
    wr_tag = '0; wr_exit = '0; wr_cfg = '0; wr_src = '0; wr_dst = '0;
    arr_done = 1'b0; arr_res = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset halt", {31'd0, halt}, 32'd0);
    check("R8 reset resume", {31'd0, resume}, 32'd0);
    check("R6 reset go", {31'd0, arr_go}, 32'd0);
    check("R7 reset wr_en", {31'd0, rf_wr_en}, 32'd0);
    miss(16'h0104, "R2 empty store misses");

    // fill all four entries (entries 0..3 in this order)
    write_cfg(16'h0104, f_exit(16'h0104), f_cfg(16'h0104), 3'(16'h0104));
    write_cfg(16'h0110, f_exit(16'h0110), f_cfg(16'h0110), 3'(16'h0110));
    write_cfg(16'h0120, f_exit(16'h0120), f_cfg(16'h0120), 3'(16'h0120));
    write_cfg(16'h0134, f_exit(16'h0134), f_cfg(16'h0134), 3'(16'h0134));

    // sweep 64 consecutive PCs: keys launch, all others miss
    for (int p = 16'h0100; p < 16'h0140; p++) begin
      if (is_tag(16'(p)))
        launch(16'(p), f_exit(16'(p)), f_cfg(16'(p)), 3'(p), p % 4, (p == 16'h0110), 1'b0);
      else
        miss(16'(p), "R2 sweep miss");
    end

    // R4: fifth new key evicts entry 0, the other keys survive
    write_cfg(16'h0140, f_exit(16'h0140), f_cfg(16'h0140), 3'(16'h0140));
    miss(16'h0104, "R4 oldest evicted");
    launch(16'h0140, f_exit(16'h0140), f_cfg(16'h0140), 3'(16'h0140), 2, 1'b0, 1'b0);
    launch(16'h0134, f_exit(16'h0134), f_cfg(16'h0134), 3'(16'h0134), 0, 1'b0, 1'b0);

    // R3: rewrite of an existing key replaces it in place
    write_cfg(16'h0110, 16'h0777, 12'h123, 3'd6);
    launch(16'h0110, 16'h0777, 12'h123, 3'd6, 1, 1'b0, 1'b0);
    // pointer did not move: next new key evicts entry 1 (0x0110), not entry 2
    write_cfg(16'h0150, f_exit(16'h0150), f_cfg(16'h0150), 3'd2);
    miss(16'h0110, "R3 replaced slot evicted next");
    launch(16'h0120, f_exit(16'h0120), f_cfg(16'h0120), 3'(16'h0120), 1, 1'b0, 1'b0);
    launch(16'h0150, f_exit(16'h0150), f_cfg(16'h0150), 3'd2, 3, 1'b1, 1'b0);

    // R9: rewriting the running key mid-launch leaves the launch intact
    launch(16'h0120, f_exit(16'h0120), f_cfg(16'h0120), 3'(16'h0120), 2, 1'b0, 1'b1);
    launch(16'h0120, f_exit(16'h0120) ^ 16'h0F0F, f_cfg(16'h0120) ^ 12'hFFF,
           3'(16'h0120), 1, 1'b0, 1'b0);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule